// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timing Core

This block produces the timing for a three-phase inverter. A single position counter climbs from zero to one below the programmed period and then descends back to zero, so one full period lasts twice the programmed value in clocks. Each of the three phases compares this triangle against its own duty value and drives a high-side and a low-side signal. Before reaching the pins, both signals pass through a dead-band stage and a minimum-on-time filter. Output enables, pair swapping, chopping and fault shutdown are left to a separate output stage placed downstream.

Software programs the block through a narrow write port. The values it writes are staged in shadow copies, which the core picks up only at defined points in the period. In single-update mode that point is the period start, which gives pulses symmetric about the midpoint. In double-update mode the duties are reloaded at the midpoint as well, so the two halves of a pulse can differ. A synchronisation strobe of programmable width marks every period start, and in double-update mode it also marks every midpoint. This lets an external converter sample in step with the switching. A status output shows which half of the period is running.

Top module: `pwm3_core`

## Requirements
- R1: Write map, where a write lands in its register on the clock edge at which `wr_en` is high: address 0 period, 1 dead time, 2 minimum on-time, 3 sync width, 4 mode (bit 0 set selects double update), 5, 6 and 7 the duty of phase 0, 1 and 2. A write to one duty address leaves the other phases unchanged.
- R2: With period value P (0 acts as 1), the position runs 0 up to P-1 in the first half and P-1 down to 0 in the second half. A full period is therefore 2P clocks.
- R3: `second_half` is 0 during the first P clocks of each period and 1 during the last P clocks.
- R4: Let D' = min(D, P). One clock after each cycle in which position + D' >= P, `pwm_hi[i]` is high; `pwm_lo[i]` is the complement. This gives D' high clocks per half, placed symmetrically about the midpoint.
- R5: With dead time T, each output rises only after its raw demand has held for T consecutive clocks before the current one, while falling edges are not delayed. `pwm_hi[i]` and `pwm_lo[i]` are never high together.
- R6: With minimum on-time M, the high side stays off for a whole half when D' < M. Likewise the low side stays off for a whole half when P - D' < M.
- R7: In single-update mode, the period, mode and duty values take effect only at a period start. A duty written mid-period changes nothing until the next period.
- R8: In double-update mode, the duty values are also reloaded at the midpoint, so the second half of the period uses a duty written during the first half.
- R9: `conv_sync` goes high for max(W, 1) clocks, beginning with the first clock of every period, where W is the sync width.
- R10: In double-update mode, `conv_sync` also goes high for max(W, 1) clocks beginning with the first clock of the second half.
- R11: While `rst_n` is low, all six PWM outputs and `conv_sync` are low, `second_half` is high, and every register reads zero. The first clock after release starts a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CW | Write value |
| pwm_hi | output | 3 | High-side drive per phase, active high |
| pwm_lo | output | 3 | Low-side drive per phase, active high |
| conv_sync | output | 1 | Converter synchronisation strobe |
| second_half | output | 1 | High while the counter descends |

## Verification
A sweep covers every period from 0 to 5. For each period, the duty runs from 0 to one past the period, so it includes the zero, full and clamped cases. The three phases get the duties D, P-D and D+1, which exposes any crosstalk between phases or mix-up of addresses. Dead times of 0 to 2 separate the immediate edge from the delayed rising edge, including windows that wrap across the period boundary. Minimum on-times of 0 to 2 separate suppressed halves from passed halves on both sides. Running each case in both update modes tells the single sync pulse per period from the double one. A separate test writes a duty early in a period and counts high clocks per half, which tells single-update loading from midpoint loading.

// File: rtl/pwm3_pkg.sv
// Shared constants for the three-phase PWM timing core.
// Assumes a fixed three-phase arrangement and a 3-bit register address space.
package pwm3_pkg;
    localparam int N_PHASE = 3;
    localparam int AW      = 3;

    localparam logic [AW-1:0] ADDR_PERIOD = 3'd0;
    localparam logic [AW-1:0] ADDR_DEAD   = 3'd1;
    localparam logic [AW-1:0] ADDR_MINON  = 3'd2;
    localparam logic [AW-1:0] ADDR_SYNCW  = 3'd3;
    localparam logic [AW-1:0] ADDR_MODE   = 3'd4;
    localparam logic [AW-1:0] ADDR_DUTY0  = 3'd5;
endpackage

// File: rtl/pwm3_regbank.sv
// Register file plus shadow copies for the PWM core.
// The live registers take writes at once. The shadows of period, mode and
// duties load on start_evt; the duties load again on mid_evt when the shadow
// mode is double update. Assumes start_evt and mid_evt never coincide.
module pwm3_regbank
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [CW-1:0]                 wr_data,
    input  logic                          start_evt,
    input  logic                          mid_evt,
    output logic [CW-1:0]                 dead_r,
    output logic [CW-1:0]                 minon_r,
    output logic [CW-1:0]                 syncw_r,
    output logic [CW-1:0]                 period_sh,
    output logic                          dbl_sh,
    output logic [N_PHASE-1:0][CW-1:0]    duty_sh
);
    logic [CW-1:0]              period_r;
    logic                       dbl_r;
    logic [N_PHASE-1:0][CW-1:0] duty_r;

    // Live scalar registers written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_r <= '0;
            dead_r   <= '0;
            minon_r  <= '0;
            syncw_r  <= '0;
            dbl_r    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PERIOD: period_r <= wr_data;
                ADDR_DEAD:   dead_r   <= wr_data;
                ADDR_MINON:  minon_r  <= wr_data;
                ADDR_SYNCW:  syncw_r  <= wr_data;
                ADDR_MODE:   dbl_r    <= wr_data[0];
                default:     ;
            endcase
        end
    end

    // Period and mode shadows follow the live values at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_sh <= '0;
            dbl_sh    <= 1'b0;
        end else if (start_evt) begin
            period_sh <= period_r;
            dbl_sh    <= dbl_r;
        end
    end

    for (genvar i = 0; i < N_PHASE; i++) begin : g_duty
        localparam logic [AW-1:0] MY_ADDR = ADDR_DUTY0 + AW'(i);

        // Live duty register of one phase.
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_r[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                duty_r[i] <= wr_data;
        end

        // Duty shadow loads at the start, and at the midpoint in double mode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_sh[i] <= '0;
            else if (start_evt || (mid_evt && dbl_sh))
                duty_sh[i] <= duty_r[i];
        end
    end
endmodule

// File: rtl/pwm3_timebase.sv
// Triangle position counter, half flag and converter sync strobe.
// The position rises 0..P-1, holds for one step while the half flag turns,
// and falls back to 0. Reset leaves the flag in the second half at position 0,
// so the first clock after reset is a period start. Assumes period_sh is
// updated only on start_evt.
module pwm3_timebase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_sh,
    input  logic          dbl_sh,
    input  logic [CW-1:0] syncw_r,
    output logic [CW-1:0] pos,
    output logic [CW-1:0] p_eff,
    output logic          second_half,
    output logic          start_evt,
    output logic          mid_evt,
    output logic          sync_out
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] last_pos;
    logic [CW-1:0] sync_left;
    logic [CW-1:0] sync_len;

    // Effective period and turning point; zero acts as one.
    always_comb begin
        p_eff     = (period_sh == '0) ? ONE : period_sh;
        last_pos  = p_eff - ONE;
        start_evt = second_half && (pos == '0);
        mid_evt   = !second_half && (pos >= last_pos);
        sync_len  = (syncw_r == '0) ? ONE : syncw_r;
    end

    // Advance the triangle position and the half flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos         <= '0;
            second_half <= 1'b1;
        end else if (second_half) begin
            if (pos == '0)
                second_half <= 1'b0;
            else
                pos <= pos - ONE;
        end else begin
            if (pos >= last_pos)
                second_half <= 1'b1;
            else
                pos <= pos + ONE;
        end
    end

    // Count down the remaining sync width, reloaded at each sync point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_left <= '0;
        else if (start_evt || (mid_evt && dbl_sh))
            sync_left <= sync_len;
        else if (sync_left != '0)
            sync_left <= sync_left - ONE;
    end

    assign sync_out = (sync_left != '0);
endmodule

// File: rtl/pwm3_phase.sv
// One phase: duty compare, minimum on-time filter and dead band.
// The raw high side is demanded when pos + min(duty, p_eff) >= p_eff, and the
// raw low side otherwise; a side whose on-time per half is below the minimum
// is not demanded at all. Each side then waits dead clocks before rising.
// Outputs are registered, one clock behind the position.
module pwm3_phase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] p_eff,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] minon,
    input  logic [CW-1:0] dead,
    output logic          drv_hi,
    output logic          drv_lo
);
    localparam int SIDES = 2;

    logic [CW-1:0]    on_time;
    logic [CW-1:0]    off_time;
    logic [CW:0]      reach;
    logic             in_on;
    logic [SIDES-1:0] raw;
    logic [SIDES-1:0] drv;

    // Clamp duty, find the on window and apply the minimum on-time filter.
    always_comb begin
        on_time  = (duty > p_eff) ? p_eff : duty;
        off_time = p_eff - on_time;
        reach    = {1'b0, pos} + {1'b0, on_time};
        in_on    = reach >= {1'b0, p_eff};
        raw[0]   = in_on && (on_time >= minon);
        raw[1]   = !in_on && (off_time >= minon);
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        logic [CW-1:0] held;

        // Count consecutive clocks of raw demand, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n || !raw[s])
                held <= '0;
            else if (held != '1)
                held <= held + CW'(1);
        end

        // Drive once the demand has already held for the dead time.
        always_ff @(posedge clk) begin
            if (!rst_n)
                drv[s] <= 1'b0;
            else
                drv[s] <= raw[s] && (held >= dead);
        end
    end

    assign drv_hi = drv[0];
    assign drv_lo = drv[1];
endmodule

// File: rtl/pwm3_core.sv
// Top of the three-phase centre-aligned PWM timing core.
// Ties the register bank, the triangle time base and three phase slices.
// Assumes a downstream stage handles enables, swapping and shutdown.
module pwm3_core
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [CW-1:0]      wr_data,
    output logic [N_PHASE-1:0] pwm_hi,
    output logic [N_PHASE-1:0] pwm_lo,
    output logic               conv_sync,
    output logic               second_half
);
    logic [CW-1:0]              dead_r;
    logic [CW-1:0]              minon_r;
    logic [CW-1:0]              syncw_r;
    logic [CW-1:0]              period_sh;
    logic                       dbl_sh;
    logic [N_PHASE-1:0][CW-1:0] duty_sh;
    logic [CW-1:0]              pos;
    logic [CW-1:0]              p_eff;
    logic                       start_evt;
    logic                       mid_evt;

    pwm3_regbank #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .start_evt (start_evt),
        .mid_evt   (mid_evt),
        .dead_r    (dead_r),
        .minon_r   (minon_r),
        .syncw_r   (syncw_r),
        .period_sh (period_sh),
        .dbl_sh    (dbl_sh),
        .duty_sh   (duty_sh)
    );

    pwm3_timebase #(.CW(CW)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_sh   (period_sh),
        .dbl_sh      (dbl_sh),
        .syncw_r     (syncw_r),
        .pos         (pos),
        .p_eff       (p_eff),
        .second_half (second_half),
        .start_evt   (start_evt),
        .mid_evt     (mid_evt),
        .sync_out    (conv_sync)
    );

    for (genvar i = 0; i < N_PHASE; i++) begin : g_ph
        pwm3_phase #(.CW(CW)) u_phase (
            .clk    (clk),
            .rst_n  (rst_n),
            .pos    (pos),
            .p_eff  (p_eff),
            .duty   (duty_sh[i]),
            .minon  (minon_r),
            .dead   (dead_r),
            .drv_hi (pwm_hi[i]),
            .drv_lo (pwm_lo[i])
        );
    end
endmodule

// File: rtl/pwm3_core_chk.sv
// Property checker for pwm3_core, attached through bind below.
// Watches the ports plus the position, effective period, shadow mode and
// dead-time register from inside the top.
module pwm3_core_chk
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PHASE-1:0] pwm_hi,
    input logic [N_PHASE-1:0] pwm_lo,
    input logic               conv_sync,
    input logic               second_half,
    input logic [CW-1:0]      pos,
    input logic [CW-1:0]      p_eff,
    input logic               dbl_sh,
    input logic [CW-1:0]      dead_r
);
    // R5: the two sides of a pair are never driven together.
    p_pair_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_hi & pwm_lo) == '0);

    // R2: the position stays inside the effective period.
    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pos < p_eff);

    // R3: the half flag changes only at a turning point of the triangle.
    p_half_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(second_half) |-> (pos == '0 || pos == p_eff - CW'(1)));

    // R9: every period start carries a sync strobe.
    p_start_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(second_half) |-> conv_sync);

    // R10: in double update the midpoint carries a sync strobe too.
    p_mid_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(second_half) && dbl_sh) |-> conv_sync);

    for (genvar i = 0; i < N_PHASE; i++) begin : g_dead
        // R5: with a dead time set, the high side cannot rise right after the low side.
        p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (dead_r != '0 && pwm_lo[i]) |=> !pwm_hi[i]);
    end
endmodule

bind pwm3_core pwm3_core_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_hi      (pwm_hi),
    .pwm_lo      (pwm_lo),
    .conv_sync   (conv_sync),
    .second_half (second_half),
    .pos         (pos),
    .p_eff       (p_eff),
    .dbl_sh      (dbl_sh),
    .dead_r      (dead_r)
);

// File: tb/pwm3_core_test.sv
`timescale 1ns/1ps
module pwm3_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  pwm_hi;
    logic [2:0]  pwm_lo;
    logic        conv_sync;
    logic        second_half;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwm3_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .conv_sync(conv_sync), .second_half(second_half)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = 16'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Returns at the negedge inside the first clock of a new period.
    task automatic wait_start();
        logic ph;
        ph = second_half;
        forever begin
            @(negedge clk);
            if (!second_half && ph) break;
            ph = second_half;
        end
    endtask

    // Raw demand of one side at period index k.
    function automatic bit raw_side(int side, int k, int pe, int d, int m);
        int pos, eff;
        bit on;
        pos = (k < pe) ? k : (2*pe - 1 - k);
        eff = (d > pe) ? pe : d;
        on  = (pos + eff >= pe);
        if (side == 0) return (eff >= m) && on;
        return ((pe - eff) >= m) && !on;
    endfunction

    // Expected registered output at period index k (one clock of latency).
    function automatic bit exp_side(int side, int k, int pe, int d, int m, int dt);
        for (int j = 1; j <= dt + 1; j++) begin
            int kk;
            kk = ((k - j) % (2*pe) + 2*pe) % (2*pe);
            if (!raw_side(side, kk, pe, d, m)) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic run_cfg(input int p, input int d, input int dt, input int m, input int dbl);
        int pe, we, w;
        int dv[3];
        string tag;
        pe = (p == 0) ? 1 : p;
        w  = (d + dt) % 3;
        we = (w == 0) ? 1 : w;
        dv[0] = d;
        dv[1] = (d > pe) ? 0 : pe - d;
        dv[2] = d + 1;
        wr(3'd0, p);
        wr(3'd1, dt);
        wr(3'd2, m);
        wr(3'd3, w);
        wr(3'd4, dbl);
        wr(3'd5, dv[0]);
        wr(3'd6, dv[1]);
        wr(3'd7, dv[2]);
        wait_start();
        wait_start();
        tag = (dt > 0) ? "R5" : ((m > 0) ? "R6" : "R4");
        for (int k = 0; k < 2*pe; k++) begin
            logic [2:0] eh, el;
            bit es;
            if (k > 0) @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                eh[i] = exp_side(0, k, pe, dv[i], m, dt);
                el[i] = exp_side(1, k, pe, dv[i], m, dt);
            end
            es = (k < we) || (dbl != 0 && k >= pe && k < pe + we);
            chk(pwm_hi == eh, {tag, " high side"}, int'(pwm_hi), int'(eh));
            chk(pwm_lo == el, {tag, " low side"}, int'(pwm_lo), int'(el));
            chk(conv_sync == es, (dbl != 0 && k >= pe) ? "R10 sync" : "R9 sync",
                int'(conv_sync), int'(es));
            chk(second_half == (k >= pe), "R3 half flag", int'(second_half), int'(k >= pe));
        end
        @(negedge clk);
        // R2: the next period starts exactly 2P clocks later.
        chk(!second_half && conv_sync, "R2 period length",
            int'({second_half, conv_sync}), 1);
    endtask

    // Writes phase 0's duty in the first clock of a period and counts high clocks per half.
    task automatic run_update(input int dbl);
        int h0a, h0b, h1a, h1b, n0;
        wr(3'd0, 6);
        wr(3'd1, 0);
        wr(3'd2, 0);
        wr(3'd3, 1);
        wr(3'd4, dbl);
        wr(3'd5, 2);
        wr(3'd6, 2);
        wr(3'd7, 2);
        wait_start();
        wait_start();
        wr(3'd5, 5);
        h0a = 0; h0b = 0; h1a = 0; h1b = 0;
        for (int k = 1; k <= 12; k++) begin
            if (k <= 6) begin h0a += int'(pwm_hi[0]); h1a += int'(pwm_hi[1]); end
            else        begin h0b += int'(pwm_hi[0]); h1b += int'(pwm_hi[1]); end
            @(negedge clk);
        end
        if (dbl != 0) begin
            chk(h0a == 2, "R8 first half keeps old duty", h0a, 2);
            chk(h0b == 5, "R8 second half takes new duty", h0b, 5);
        end else begin
            chk(h0a == 2, "R7 first half old duty", h0a, 2);
            chk(h0b == 2, "R7 second half still old duty", h0b, 2);
        end
        chk(h1a == 2 && h1b == 2, "R1 other phase untouched", h1a + h1b, 4);
        wait_start();
        n0 = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            n0 += int'(pwm_hi[0]);
        end
        chk(n0 == 10, (dbl != 0) ? "R8 next period new duty" : "R7 next period new duty", n0, 10);
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (4) @(negedge clk);
        chk(pwm_hi == 3'b000 && pwm_lo == 3'b000, "R11 drives low in reset",
            int'({pwm_hi, pwm_lo}), 0);
        chk(!conv_sync, "R11 sync low in reset", int'(conv_sync), 0);
        chk(second_half, "R11 half flag high in reset", int'(second_half), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_sync && !second_half, "R11 first clock starts period",
            int'({conv_sync, second_half}), 2);

        for (int p = 0; p <= 5; p++) begin
            int pe;
            pe = (p == 0) ? 1 : p;
            for (int d = 0; d <= pe + 1; d++)
                for (int dt = 0; dt <= 2; dt++)
                    for (int m = 0; m <= 2; m++)
                        for (int dbl = 0; dbl <= 1; dbl++)
                            run_cfg(p, d, dt, m, dbl);
        end

        run_update(1);
        run_update(0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule